// File: doc/BRIEF.md
# Stall-Driven Local Clock Halt Controller

This block produces the clock for one processor core from a free-running reference clock. The reference clock stands in for the local oscillator. The controller divides the clock by a programmable integer and stops it when the core can make no progress. The core cannot make progress when it wants to read from an input FIFO that holds nothing, or to write into an output FIFO that has no room. When either condition appears, the controller first lets the core clock run for a fixed number of core cycles, so that the pipeline can drain. It then holds the core clock low until the blocking condition goes away, and restarts the clock in under one reference period.

All control state is clocked by the reference clock, so the stall watcher keeps running while the core clock is stopped. A single latch that is transparent while the reference clock is low, followed by an AND gate, makes every core clock pulse. Division works by swallowing pulses. Each core pulse is therefore exactly one high phase of the reference clock, and neither gating nor a change of ratio can shorten a pulse. A ratio change waits for the end of the period in progress.

Top module: `lclk_halt_ctrl`

## Requirements
- R1: `stall` is high exactly when `in_empty_rd` or `out_full_wr` is high. It follows them without waiting for a clock edge.
- R2: While `stall` stays high, the core clock delivers exactly 9 rising edges, counting those reference edges at which `stall` was already high. `halted` then goes high, and no further core edge occurs while the stall persists.
- R3: If `stall` drops before the ninth edge, the drain count restarts from zero and `halted` stays low. A later stall again allows a full 9 core edges.
- R4: When `stall` drops while halted, a core rising edge occurs at the very next reference rising edge, and `halted` is low after that edge.
- R5: `div_code` value k (0 to 127) gives one core rising edge every k+1 reference cycles.
- R6: A new `div_code` takes effect only at a period boundary. A change made just after a core edge leaves the current period at its old length, and the next period uses the new length.
- R7: Every core clock high pulse lasts exactly one reference high phase (2 ns at 250 MHz), so no runt pulse ever appears.
- R8: While `rst_n` is low, `halted` is low and the core clock runs at the undivided reference rate. After release the divider keeps ratio 1 until its first boundary, where it loads `div_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_empty_rd | input | 1 | Core is reading an empty input FIFO |
| out_full_wr | input | 1 | Core is writing a full output FIFO |
| div_code | input | 7 | Divide ratio minus one |
| core_clk | output | 1 | Gated, divided core clock |
| stall | output | 1 | FIFO-blocked flag |
| halted | output | 1 | Core clock is stopped |

## Verification
Suppose the drain counter does not clear when a stall aborts. The number of core edges during the next stall then falls short of nine, so the error shows within one drain interval. A divider that loads its code in the middle of a period, or that does not park while halted, shows up as a wrong edge spacing at the first edge after a ratio change or after a release. A latch that passes its enable during the high phase would produce a pulse shorter than one reference high phase, and the bench measures the width of every pulse.

// File: rtl/lclk_pkg.sv
`timescale 1ns/1ps
package lclk_pkg;
   parameter int unsigned LCLK_DRAIN_DEFAULT   = 9;
   parameter int unsigned LCLK_MAX_DIV_DEFAULT = 128;

   function automatic int unsigned lclk_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lclk_divider.sv
`timescale 1ns/1ps
module lclk_divider
   import lclk_pkg::*;
#(
   parameter int unsigned MAX_DIV = LCLK_MAX_DIV_DEFAULT,
   localparam int unsigned DW     = lclk_width(MAX_DIV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_i,
   input  logic [DW-1:0] code_i,
   output logic          tick_o
);
   generate
      if (MAX_DIV == 1) begin : g_bypass
         assign tick_o = 1'b1;
      end else begin : g_count
         logic [DW-1:0] cnt_q;
         logic [DW-1:0] code_q;
         logic          wrap;

         assign wrap   = (cnt_q == code_q);
         assign tick_o = (cnt_q == '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               code_q <= '0;
            end else if (hold_i || wrap) begin
               cnt_q  <= '0;
               code_q <= code_i;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
            end
         end

         AST_MIDPERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q != '0) |-> $stable(code_q)); // R6
         AST_HOLD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
            hold_i |=> (cnt_q == '0)); // R4
      end
   endgenerate
endmodule

// File: rtl/lclk_drain.sv
`timescale 1ns/1ps
module lclk_drain
   import lclk_pkg::*;
#(
   parameter int unsigned DRAIN = LCLK_DRAIN_DEFAULT,
   localparam int unsigned CW   = lclk_width(DRAIN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stall_i,
   input  logic core_edge_i,
   output logic halt_o
);
   localparam logic [CW-1:0] LAST = CW'(DRAIN - 1);

   logic [CW-1:0] cnt_q;
   logic          halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         halt_q <= 1'b0;
      end else if (!stall_i) begin
         cnt_q  <= '0;
         halt_q <= 1'b0;
      end else if (!halt_q && core_edge_i) begin
         if (cnt_q == LAST) halt_q <= 1'b1;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign halt_o = halt_q;

   AST_HALT_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_q) |-> ($past(cnt_q) == LAST)); // R2
   AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !stall_i) |=> !halt_q); // R4
   AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_i |=> (cnt_q == '0 && !halt_q)); // R3
endmodule

// File: rtl/lclk_gate.sv
`timescale 1ns/1ps
module lclk_gate (
   input  logic clk_i,
   input  logic en_i,
   output logic gclk_o
);
   logic en_lat;

   always_latch begin
      if (!clk_i) en_lat = en_i;
   end

   assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/lclk_halt_ctrl.sv
`timescale 1ns/1ps
module lclk_halt_ctrl
   import lclk_pkg::*;
#(
   parameter int unsigned DRAIN   = LCLK_DRAIN_DEFAULT,
   parameter int unsigned MAX_DIV = LCLK_MAX_DIV_DEFAULT,
   localparam int unsigned DW     = lclk_width(MAX_DIV)
) (
   input  logic          ref_clk,
   input  logic          rst_n,
   input  logic          in_empty_rd,
   input  logic          out_full_wr,
   input  logic [DW-1:0] div_code,
   output logic          core_clk,
   output logic          stall,
   output logic          halted
);
   initial begin : g_param_check
      assert (DRAIN >= 1) else $error("DRAIN must be at least 1");
      assert (MAX_DIV >= 1) else $error("MAX_DIV must be at least 1");
   end

   logic tick;
   logic halt;
   logic hold;
   logic gate_en;

   assign stall   = in_empty_rd | out_full_wr;
   assign hold    = halt & stall;
   assign gate_en = tick & ~hold;
   assign halted  = halt;

   lclk_divider #(.MAX_DIV(MAX_DIV)) u_div (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .hold_i (hold),
      .code_i (div_code),
      .tick_o (tick)
   );

   lclk_drain #(.DRAIN(DRAIN)) u_drain (
      .clk         (ref_clk),
      .rst_n       (rst_n),
      .stall_i     (stall),
      .core_edge_i (gate_en),
      .halt_o      (halt)
   );

   lclk_gate u_gate (
      .clk_i  (ref_clk),
      .en_i   (gate_en),
      .gclk_o (core_clk)
   );

   AST_HALT_NEEDS_STALL: assert property (@(posedge ref_clk) disable iff (!rst_n)
      halted |-> $past(stall)); // R2
endmodule

// File: tb/lclk_halt_ctrl_bench.sv
`timescale 1ns/1ps
module lclk_halt_ctrl_bench;
   logic       ref_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_empty_rd = 1'b0;
   logic       out_full_wr = 1'b0;
   logic [6:0] div_code = 7'd0;
   wire        core_clk;
   wire        stall;
   wire        halted;

   int      n_run = 0;
   int      n_fail = 0;
   int      core_cnt = 0;
   int      last_gap = 0;
   int      width_bad = 0;
   realtime last_rise = 0.0;
   bit      done = 1'b0;

   always #2 ref_clk = ~ref_clk;

   lclk_halt_ctrl u_lclk_halt_ctrl (
      .ref_clk     (ref_clk),
      .rst_n       (rst_n),
      .in_empty_rd (in_empty_rd),
      .out_full_wr (out_full_wr),
      .div_code    (div_code),
      .core_clk    (core_clk),
      .stall       (stall),
      .halted      (halted)
   );

   always @(posedge core_clk) begin
      last_gap  = int'(($realtime - last_rise) / 4.0);
      last_rise = $realtime;
      core_cnt++;
   end

   always @(negedge core_clk) begin
      if ((($realtime - last_rise) > 2.1) || (($realtime - last_rise) < 1.9))
         width_bad++;
   end

   function automatic int exp_gap(input int code);
      return code + 1;
   endfunction

   function automatic int drain_wait(input int code);
      return 11 * (code + 1) + 20;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge ref_clk); #1;
   endtask

   task automatic cyc(input int n);
      repeat (n) step();
   endtask

   task automatic core_step();
      @(posedge core_clk); #1;
   endtask

   task automatic set_ratio(input int code);
      div_code = 7'(code);
      repeat (3) core_step();
      core_step();
      chk(last_gap == exp_gap(code), "R5 divided period", last_gap, exp_gap(code));
   endtask

   task automatic release_check();
      int c1;
      in_empty_rd = 1'b0;
      out_full_wr = 1'b0;
      c1 = core_cnt;
      step();
      chk(core_cnt == c1 + 1, "R4 edge on next ref edge", core_cnt - c1, 1);
      chk(halted == 1'b0, "R4 halted cleared", int'(halted), 0);
   endtask

   task automatic drain_test(input int code, input bit use_out);
      int c0;
      int c1;
      set_ratio(code);
      step();
      if (use_out) out_full_wr = 1'b1;
      else         in_empty_rd = 1'b1;
      c0 = core_cnt;
      cyc(drain_wait(code));
      chk(core_cnt - c0 == 9, "R2 drain edge count", core_cnt - c0, 9);
      chk(halted == 1'b1, "R2 halted raised", int'(halted), 1);
      c1 = core_cnt;
      cyc(2 * exp_gap(code) + 5);
      chk(core_cnt == c1, "R2 no edge while halted", core_cnt - c1, 0);
      release_check();
   endtask

   task automatic abort_test(input int code, input int k);
      int c0;
      int c2;
      set_ratio(code);
      step();
      in_empty_rd = 1'b1;
      c0 = core_cnt;
      while (core_cnt - c0 < k) step();
      in_empty_rd = 1'b0;
      c2 = core_cnt;
      cyc(4 * exp_gap(code) + 20);
      chk(halted == 1'b0, "R3 no halt after abort", int'(halted), 0);
      chk(core_cnt > c2, "R3 clock keeps running", core_cnt - c2, 1);
      in_empty_rd = 1'b1;
      c0 = core_cnt;
      cyc(drain_wait(code));
      chk(core_cnt - c0 == 9, "R3 full drain after abort", core_cnt - c0, 9);
      release_check();
   endtask

   task automatic change_test(input int old_code, input int new_code);
      set_ratio(old_code);
      core_step();
      div_code = 7'(new_code);
      core_step();
      chk(last_gap == exp_gap(old_code), "R6 current period keeps old ratio",
          last_gap, exp_gap(old_code));
      core_step();
      chk(last_gap == exp_gap(new_code), "R6 next period uses new ratio",
          last_gap, exp_gap(new_code));
   endtask

   initial begin
      #(4.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd20517);
      div_code = 7'd3;
      cyc(3);
      // R8 reset state, R1 combinational stall flag
      chk(halted == 1'b0, "R8 halted low in reset", int'(halted), 0);
      in_empty_rd = 1'b1;
      #1;
      chk(stall == 1'b1, "R1 stall from input empty", int'(stall), 1);
      cyc(15);
      chk(halted == 1'b0, "R8 no halt while reset", int'(halted), 0);
      in_empty_rd = 1'b0;
      out_full_wr = 1'b1;
      #1;
      chk(stall == 1'b1, "R1 stall from output full", int'(stall), 1);
      out_full_wr = 1'b0;
      #1;
      chk(stall == 1'b0, "R1 no stall", int'(stall), 0);
      in_empty_rd = 1'b1;
      out_full_wr = 1'b1;
      #1;
      chk(stall == 1'b1, "R1 stall both", int'(stall), 1);
      in_empty_rd = 1'b0;
      out_full_wr = 1'b0;
      step();
      chk(last_gap == 1, "R8 full rate during reset", last_gap, 1);
      rst_n = 1'b1;
      core_step();
      core_step();
      chk(last_gap == 1, "R8 ratio one until first boundary", last_gap, 1);
      core_step();
      chk(last_gap == 4, "R8 loaded code at boundary", last_gap, 4);

      // directed corners
      drain_test(0, 1'b0);
      drain_test(127, 1'b1);
      drain_test(2, 1'b1);
      abort_test(0, 8);
      abort_test(3, 1);
      change_test(4, 1);
      change_test(1, 6);
      change_test(127, 0);

      // constrained random
      for (int i = 0; i < 6; i++) begin
         int code;
         code = int'($urandom_range(0, 12));
         drain_test(code, 1'($urandom_range(0, 1)));
         abort_test(int'($urandom_range(0, 12)), int'($urandom_range(1, 8)));
         change_test(int'($urandom_range(1, 20)), int'($urandom_range(0, 20)));
      end

      chk(width_bad == 0, "R7 every pulse one ref high phase", width_bad, 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule